// File: doc/BRIEF.md
# Banked Interrupt Binary-Point Register Bank

This block keeps the binary-point settings used by the CPU side of an interrupt controller. Three physical fields are stored: one for group 0, one for secure group 1 and one for non-secure group 1. Two virtual fields live beside them as a hypervisor-owned copy. Each cycle a register request names one of four access targets. The block combines that request with the current exception level, the security state, two common-binary-point control bits, one virtual common bit and two hypervisor routing bits. From these it returns the effective value, or it sends the access to the physical or the virtual field.

Reads are combinational from the request and the stored state. A write is a one-cycle strobe that updates state on the rising clock edge. Requests are plain register accesses that always complete, so there is no back-pressure: a write strobe is taken in the cycle it is high. The block also drives the effective binary point of each group continuously, for the priority-grouping logic next to it.

Parameters: `SEC_MIN` is the secure floor (default 2). The non-secure floor is derived as `SEC_MIN + 1`. `DATA_W` is the width of the request data.

Top module: `binpt_bank`

## Requirements
- R1: After reset, the group-0, secure group-1 and virtual group-0 fields hold the secure floor (2). The non-secure group-1 and virtual group-1 fields hold the non-secure floor (3).
- R2: Before any other processing, write data is cut to its low 3 bits, so writing 0xF5 to `acc_sel`=0 stores 5.
- R3: A write to `acc_sel`=1 in secure state below EL3 (`cur_el`!=3) is raised to at least the secure floor. If `el3_impl` and `s_common` are both set, it goes to the group-0 field; otherwise it goes to the secure group-1 field.
- R4: A write to `acc_sel`=1 outside the secure-below-EL3 case is raised to at least the non-secure floor. It is ignored when `el3_impl` and `ns_common` are set and `cur_el`!=3; otherwise it goes to the non-secure group-1 field.
- R5: A read of `acc_sel`=1 in secure state below EL3 returns the group-0 field when `s_common` is set. Otherwise it returns the secure group-1 field, no lower than the secure floor.
- R6: A non-secure read of `acc_sel`=1 with `el3_impl`, `ns_common` and `cur_el`!=3 returns the group-0 field plus one, saturated at 7. Otherwise it returns the non-secure group-1 field, no lower than the non-secure floor.
- R7: At `cur_el`=1 with `in_secure`=0, reads and writes of `acc_sel`=0 go to the virtual group-0 field when `fiq_route` is set. Reads and writes of `acc_sel`=1 go to the virtual group-1 view when `irq_route` is set. At any other level no redirection happens.
- R8: `acc_sel`=2 reads and writes the virtual group-0 field directly. `acc_sel`=3 reads the virtual group-0 field plus one, saturated at 7, when `v_common` is set, and the virtual group-1 field otherwise. A virtual group-1 write is ignored while `v_common` is set and is stored unclamped otherwise.
- R9: At `cur_el`=3, group-1 accesses use the non-secure group-1 path whatever `in_secure` is.
- R10: `bp_g0`, `bp_g1s` and `bp_g1ns` give the values that a group-0 read, a secure group-1 read and a non-secure group-1 read would return at the current level, including redirection for group 0 and non-secure group 1.
- R11: A group-0 read with no redirection returns the stored group-0 field, zero-extended to `DATA_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_wr | input | 1 | One-cycle write strobe |
| acc_sel | input | 2 | Target: 0 group 0, 1 group 1, 2 virtual group 0, 3 virtual group 1 |
| wr_data | input | DATA_W | Write data; only the low 3 bits are used |
| rd_data | output | DATA_W | Combinational read data for `acc_sel` |
| cur_el | input | 2 | Current exception level, 0 to 3 |
| in_secure | input | 1 | Requester is in secure state |
| el3_impl | input | 1 | EL3 is implemented |
| s_common | input | 1 | Secure common-binary-point control bit |
| ns_common | input | 1 | Non-secure common-binary-point control bit |
| fiq_route | input | 1 | Hypervisor FIQ routing bit (group-0 redirection) |
| irq_route | input | 1 | Hypervisor IRQ routing bit (group-1 redirection) |
| v_common | input | 1 | Virtual common-binary-point bit |
| bp_g0 | output | 3 | Effective group-0 binary point |
| bp_g1s | output | 3 | Effective secure group-1 binary point |
| bp_g1ns | output | 3 | Effective non-secure group-1 binary point |

## Verification
The hardest case to show is a write that is dropped. A dropped write leaves nothing at the ports until the aliasing is lifted again. The bench therefore stores a known non-secure group-1 value, sets `ns_common` and issues the write. It then clears `ns_common` and reads back the earlier value. The secure write that lands in group 0 is handled the same way, by toggling `s_common` and `el3_impl` between a write and the reads that follow it. Saturation at 7 is reached by first loading 7 into the group-0 field or the virtual group-0 field through the normal write path.

// File: rtl/bpr_pkg.sv
package bpr_pkg;
  localparam int BP_W    = 3;
  localparam int NUM_FLD = 5;
  localparam int FLD_IW  = 3;

  localparam logic [FLD_IW-1:0] F_G0   = 3'd0;
  localparam logic [FLD_IW-1:0] F_G1S  = 3'd1;
  localparam logic [FLD_IW-1:0] F_G1NS = 3'd2;
  localparam logic [FLD_IW-1:0] F_V0   = 3'd3;
  localparam logic [FLD_IW-1:0] F_V1   = 3'd4;

  typedef enum logic [1:0] {
    ACC_BP0  = 2'd0,
    ACC_BP1  = 2'd1,
    ACC_VBP0 = 2'd2,
    ACC_VBP1 = 2'd3
  } acc_e;

  typedef logic [BP_W-1:0] bp_t;

  function automatic bp_t bp_sat_inc(input bp_t v);
    return (v == '1) ? v : bp_t'(v + 1'b1);
  endfunction

  function automatic bp_t bp_floor(input bp_t v, input bp_t lo);
    return (v < lo) ? lo : v;
  endfunction
endpackage

// File: rtl/bpr_field_store.sv
module bpr_field_store
  import bpr_pkg::*;
#(
  parameter int SEC_MIN = 2,
  parameter int NS_MIN  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_go,
  input  logic [FLD_IW-1:0]        wr_fld,
  input  bp_t                      wr_val,
  output logic [NUM_FLD-1:0][BP_W-1:0] fields
);
  function automatic bp_t rst_val(input int idx);
    if (idx == int'(F_G1NS) || idx == int'(F_V1)) return bp_t'(NS_MIN);
    return bp_t'(SEC_MIN);
  endfunction

  for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fields[i] <= rst_val(i);
      end else if (wr_go && (wr_fld == FLD_IW'(i))) begin
        fields[i] <= wr_val;
      end
    end
  end

  // R3
  g1s_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fields[F_G1S] >= bp_t'(SEC_MIN));
  // R4
  g1ns_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fields[F_G1NS] >= bp_t'(NS_MIN));
endmodule

// File: rtl/bpr_view.sv
module bpr_view
  import bpr_pkg::*;
#(
  parameter int SEC_MIN = 2,
  parameter int NS_MIN  = 3
) (
  input  logic [NUM_FLD-1:0][BP_W-1:0] fields,
  input  logic [1:0] cur_el,
  input  logic       in_secure,
  input  logic       el3_impl,
  input  logic       s_common,
  input  logic       ns_common,
  input  logic       fiq_route,
  input  logic       irq_route,
  input  logic       v_common,
  output logic       redir0,
  output logic       redir1,
  output logic       sec_path,
  output logic       ns_alias,
  output bp_t        g0_view,
  output bp_t        g1s_view,
  output bp_t        g1ns_phys,
  output bp_t        g1ns_view,
  output bp_t        v1_view
);
  logic ns_el1;
  logic below_el3;

  always_comb begin
    below_el3 = (cur_el != 2'd3);
    ns_el1    = (cur_el == 2'd1) && !in_secure;
    redir0    = ns_el1 && fiq_route;
    redir1    = ns_el1 && irq_route;
    sec_path  = in_secure && below_el3;
    ns_alias  = el3_impl && below_el3 && ns_common;

    v1_view   = v_common ? bp_sat_inc(fields[F_V0]) : fields[F_V1];
    g0_view   = redir0 ? fields[F_V0] : fields[F_G0];
    g1s_view  = (below_el3 && s_common) ? fields[F_G0]
                                        : bp_floor(fields[F_G1S], bp_t'(SEC_MIN));
    g1ns_phys = ns_alias ? bp_sat_inc(fields[F_G0])
                         : bp_floor(fields[F_G1NS], bp_t'(NS_MIN));
    g1ns_view = redir1 ? v1_view : g1ns_phys;
  end
endmodule

// File: rtl/bpr_write_route.sv
module bpr_write_route
  import bpr_pkg::*;
#(
  parameter int SEC_MIN = 2,
  parameter int NS_MIN  = 3
) (
  input  logic              acc_wr,
  input  logic [1:0]        acc_sel,
  input  bp_t               wr_low,
  input  logic              el3_impl,
  input  logic              s_common,
  input  logic              v_common,
  input  logic              redir0,
  input  logic              redir1,
  input  logic              sec_path,
  input  logic              ns_alias,
  output logic              wr_go,
  output logic [FLD_IW-1:0] wr_fld,
  output bp_t               wr_val
);
  logic vwr1_go;

  always_comb begin
    vwr1_go = !v_common;
    wr_go   = 1'b0;
    wr_fld  = F_G0;
    wr_val  = wr_low;
    unique case (acc_e'(acc_sel))
      ACC_BP0: begin
        wr_go  = acc_wr;
        wr_fld = redir0 ? F_V0 : F_G0;
      end
      ACC_BP1: begin
        if (redir1) begin
          wr_go  = acc_wr && vwr1_go;
          wr_fld = F_V1;
        end else if (sec_path) begin
          wr_go  = acc_wr;
          wr_val = bp_floor(wr_low, bp_t'(SEC_MIN));
          wr_fld = (el3_impl && s_common) ? F_G0 : F_G1S;
        end else begin
          wr_go  = acc_wr && !ns_alias;
          wr_val = bp_floor(wr_low, bp_t'(NS_MIN));
          wr_fld = F_G1NS;
        end
      end
      ACC_VBP0: begin
        wr_go  = acc_wr;
        wr_fld = F_V0;
      end
      default: begin
        wr_go  = acc_wr && vwr1_go;
        wr_fld = F_V1;
      end
    endcase
  end
endmodule

// File: rtl/binpt_bank.sv
module binpt_bank
  import bpr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SEC_MIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_wr,
  input  logic [1:0]        acc_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [1:0]        cur_el,
  input  logic              in_secure,
  input  logic              el3_impl,
  input  logic              s_common,
  input  logic              ns_common,
  input  logic              fiq_route,
  input  logic              irq_route,
  input  logic              v_common,
  output logic [2:0]        bp_g0,
  output logic [2:0]        bp_g1s,
  output logic [2:0]        bp_g1ns
);
  localparam int NS_MIN = SEC_MIN + 1;

  logic [NUM_FLD-1:0][BP_W-1:0] fields;
  logic        redir0, redir1, sec_path, ns_alias;
  bp_t         g0_view, g1s_view, g1ns_phys, g1ns_view, v1_view;
  logic        wr_go;
  logic [FLD_IW-1:0] wr_fld;
  bp_t         wr_val;
  bp_t         wr_low;
  bp_t         rd_bp;
  logic        unused_hi;

  assign wr_low    = wr_data[BP_W-1:0];
  assign unused_hi = ^wr_data[DATA_W-1:BP_W];

  bpr_view #(.SEC_MIN(SEC_MIN), .NS_MIN(NS_MIN)) view_i (
    .fields(fields), .cur_el(cur_el), .in_secure(in_secure),
    .el3_impl(el3_impl), .s_common(s_common), .ns_common(ns_common),
    .fiq_route(fiq_route), .irq_route(irq_route), .v_common(v_common),
    .redir0(redir0), .redir1(redir1), .sec_path(sec_path), .ns_alias(ns_alias),
    .g0_view(g0_view), .g1s_view(g1s_view), .g1ns_phys(g1ns_phys),
    .g1ns_view(g1ns_view), .v1_view(v1_view)
  );

  bpr_write_route #(.SEC_MIN(SEC_MIN), .NS_MIN(NS_MIN)) route_i (
    .acc_wr(acc_wr), .acc_sel(acc_sel), .wr_low(wr_low),
    .el3_impl(el3_impl), .s_common(s_common), .v_common(v_common),
    .redir0(redir0), .redir1(redir1), .sec_path(sec_path), .ns_alias(ns_alias),
    .wr_go(wr_go), .wr_fld(wr_fld), .wr_val(wr_val)
  );

  bpr_field_store #(.SEC_MIN(SEC_MIN), .NS_MIN(NS_MIN)) store_i (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .wr_fld(wr_fld),
    .wr_val(wr_val), .fields(fields)
  );

  always_comb begin
    unique case (acc_e'(acc_sel))
      ACC_BP0:  rd_bp = g0_view;
      ACC_BP1:  rd_bp = redir1 ? v1_view : (sec_path ? g1s_view : g1ns_phys);
      ACC_VBP0: rd_bp = fields[F_V0];
      default:  rd_bp = v1_view;
    endcase
  end

  assign rd_data = DATA_W'(rd_bp);
  assign bp_g0   = g0_view;
  assign bp_g1s  = g1s_view;
  assign bp_g1ns = g1ns_view;

  // R2
  vbp0_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_sel == 2'd2) |=> (fields[F_V0] == $past(wr_data[BP_W-1:0])));
  // R4
  ns_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_sel == 2'd1 && !in_secure && el3_impl && ns_common &&
     cur_el != 2'd3 && !(cur_el == 2'd1 && irq_route))
    |=> ($stable(fields[F_G1NS]) && $stable(fields[F_G0])));
  // R8
  v1_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_sel == 2'd3 && v_common) |=> $stable(fields[F_V1]));
  // R6
  ns_alias_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (el3_impl && ns_common && cur_el != 2'd3 && !(cur_el == 2'd1 && !in_secure))
    |-> (bp_g1ns == ((bp_g0 == 3'd7) ? 3'd7 : bp_g0 + 3'd1)));
endmodule

// File: tb/binpt_bank_tb.sv
module binpt_bank_tb_top;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_wr = 1'b0;
  logic [1:0] acc_sel = 2'd0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic [1:0] cur_el = 2'd1;
  logic in_secure = 1'b0, el3_impl = 1'b1, s_common = 1'b0, ns_common = 1'b0;
  logic fiq_route = 1'b0, irq_route = 1'b0, v_common = 1'b0;
  logic [2:0] bp_g0, bp_g1s, bp_g1ns;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  binpt_bank #(.DATA_W(DATA_W), .SEC_MIN(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_sel(acc_sel),
    .wr_data(wr_data), .rd_data(rd_data), .cur_el(cur_el),
    .in_secure(in_secure), .el3_impl(el3_impl), .s_common(s_common),
    .ns_common(ns_common), .fiq_route(fiq_route), .irq_route(irq_route),
    .v_common(v_common), .bp_g0(bp_g0), .bp_g1s(bp_g1s), .bp_g1ns(bp_g1ns)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [DATA_W-1:0] d);
    @(negedge clk);
    acc_sel = sel; wr_data = d; acc_wr = 1'b1;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] sel, input int exp, input string req);
    @(negedge clk);
    acc_sel = sel;
    #1;
    check(req, int'(rd_data), exp);
  endtask

  task automatic set_ctx(input logic [1:0] el, input logic sec);
    @(negedge clk);
    cur_el = el; in_secure = sec;
  endtask

  task automatic t_reset;
    rd_chk(2'd0, 2, "R1 g0");
    rd_chk(2'd1, 3, "R1 g1ns");
    rd_chk(2'd2, 2, "R1 v0");
    rd_chk(2'd3, 3, "R1 v1");
    check("R1 bp_g1s", int'(bp_g1s), 2);
  endtask

  task automatic t_trunc;
    wr(2'd0, 8'hF5);
    rd_chk(2'd0, 5, "R2 R11 g0 trunc");
    check("R10 bp_g0", int'(bp_g0), 5);
  endtask

  task automatic t_secure;
    set_ctx(2'd1, 1'b1);
    wr(2'd1, 8'h00);
    rd_chk(2'd1, 2, "R3 secure clamp");
    wr(2'd1, 8'h06);
    rd_chk(2'd1, 6, "R5 secure g1 read");
    s_common = 1'b1;
    wr(2'd1, 8'h01);
    rd_chk(2'd0, 2, "R3 common write to g0");
    rd_chk(2'd1, 2, "R5 common read of g0");
    check("R10 bp_g1s common", int'(bp_g1s), 2);
    s_common = 1'b0;
    rd_chk(2'd1, 6, "R3 g1s kept");
    el3_impl = 1'b0; s_common = 1'b1;
    wr(2'd1, 8'h04);
    rd_chk(2'd0, 2, "R3 no el3 g0 untouched");
    s_common = 1'b0;
    rd_chk(2'd1, 4, "R3 no el3 to g1s");
    el3_impl = 1'b1;
  endtask

  task automatic t_nonsecure;
    set_ctx(2'd2, 1'b0);
    wr(2'd1, 8'h01);
    rd_chk(2'd1, 3, "R4 ns clamp");
    wr(2'd1, 8'h07);
    ns_common = 1'b1;
    rd_chk(2'd1, 3, "R6 ns alias plus one");
    wr(2'd1, 8'h05);
    ns_common = 1'b0;
    rd_chk(2'd1, 7, "R4 ns write dropped");
    wr(2'd0, 8'h07);
    ns_common = 1'b1;
    rd_chk(2'd1, 7, "R6 saturate at 7");
    check("R10 bp_g1ns", int'(bp_g1ns), 7);
    el3_impl = 1'b0;
    wr(2'd1, 8'h04);
    rd_chk(2'd1, 4, "R4 R6 no el3 path");
    el3_impl = 1'b1; ns_common = 1'b0;
  endtask

  task automatic t_el3;
    set_ctx(2'd3, 1'b1);
    rd_chk(2'd1, 4, "R9 el3 uses ns field");
    wr(2'd1, 8'h00);
    rd_chk(2'd1, 3, "R9 el3 ns clamp");
    ns_common = 1'b1;
    wr(2'd1, 8'h06);
    rd_chk(2'd1, 6, "R4 el3 write not dropped");
    ns_common = 1'b0;
    set_ctx(2'd1, 1'b1);
    rd_chk(2'd1, 4, "R9 g1s untouched");
  endtask

  task automatic t_redirect;
    set_ctx(2'd1, 1'b0);
    fiq_route = 1'b1;
    wr(2'd0, 8'h01);
    rd_chk(2'd0, 1, "R7 g0 redirect read");
    rd_chk(2'd2, 1, "R7 g0 redirect write");
    fiq_route = 1'b0;
    rd_chk(2'd0, 7, "R7 R11 g0 phys kept");
    irq_route = 1'b1;
    wr(2'd1, 8'h05);
    rd_chk(2'd1, 5, "R7 g1 redirect read");
    rd_chk(2'd3, 5, "R7 g1 redirect write");
    check("R10 bp_g1ns redirect", int'(bp_g1ns), 5);
    irq_route = 1'b0;
    rd_chk(2'd1, 6, "R7 g1ns phys kept");
    set_ctx(2'd2, 1'b0);
    fiq_route = 1'b1;
    rd_chk(2'd0, 7, "R7 no redirect at el2");
    fiq_route = 1'b0;
  endtask

  task automatic t_virtual;
    v_common = 1'b1;
    rd_chk(2'd3, 2, "R8 v1 alias plus one");
    wr(2'd3, 8'h00);
    v_common = 1'b0;
    rd_chk(2'd3, 5, "R8 v1 write ignored");
    wr(2'd2, 8'h07);
    rd_chk(2'd2, 7, "R8 v0 direct");
    v_common = 1'b1;
    rd_chk(2'd3, 7, "R8 v1 saturate");
    v_common = 1'b0;
    wr(2'd3, 8'h00);
    rd_chk(2'd3, 0, "R8 v1 unclamped");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_trunc();
    t_secure();
    t_nonsecure();
    t_el3();
    t_redirect();
    t_virtual();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule